// File: doc/BRIEF.md
# Integer PLL Divider Solver

This block turns a requested output frequency, given in whole MHz, into the settings of an integer-mode PLL that runs from a fixed reference (24 MHz by default). A single start strobe launches the computation. The block then returns a reference divider, a feedback divider and two post-dividers, together with a one-cycle done pulse and an error flag.

Targets below the lower VCO bound go through a search. The block tries post-divider pairs, one pair per clock, until the target times their product falls inside the legal VCO window. Targets at or above that bound use the target itself as the VCO frequency, with both post-dividers set to 1.

Next, an engine that subtracts once per clock computes the greatest common divisor of the reference and the VCO frequency. Two sequential dividers then divide both frequencies by that divisor, which yields the smallest divider pair for that ratio. The result is held on the outputs until the next accepted request finishes.

Top module: `pds_solver`

## Requirements
- R1: A request is rejected when the target is 0 or equals the reference frequency. A rejected request pulses done with err = 1, and refdiv, fbdiv, postdiv1 and postdiv2 all read 0.
- R2: For a target below 800 MHz, postdiv1 is the outer loop and postdiv2 the inner loop, each counting 1..7. The result is the first pair for which target × postdiv1 × postdiv2 lies within 800..2000 MHz inclusive.
- R3: For a target of 800 MHz or more, postdiv1 = postdiv2 = 1 and the VCO frequency equals the target.
- R4: With g = gcd(reference, VCO) in MHz, refdiv = reference / g and fbdiv = VCO / g, so fbdiv × reference = refdiv × VCO.
- R5: If no post-divider pair places the VCO in the window (for example target = 16), the request ends with err = 1 and all divider outputs at 0.
- R6: If the result does not fit its field (fbdiv above 4095 for 12 bits, refdiv above 63 for 6 bits), the request ends with err = 1 and all outputs at 0. Example: target 4099 gives fbdiv 4099.
- R7: done is high for exactly one cycle per finished request. The divider outputs and err change only in the cycle that done is high, and then hold.
- R8: A start strobe that arrives while a computation is in progress is ignored, and the running request completes with its own result.
- R9: After reset, done, err and all divider outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| target_mhz | input | 13 | Requested output frequency in MHz |
| refdiv | output | 6 | Reference divider |
| fbdiv | output | 12 | Feedback divider |
| postdiv1 | output | 3 | First post-divider |
| postdiv2 | output | 3 | Second post-divider |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected or unsolvable |

## Verification
The assertions check on every cycle that the divider outputs stay zero whenever err is set and that done never lasts two cycles. They also check that outputs move only with done and that any accepted result satisfies the ratio fbdiv × reference = refdiv × VCO. When post-division is used, they check that the latched VCO lies in the window. Only the bench's scenarios can show search order, meaning that the first qualifying pair wins rather than any legal pair, and that the ratio is fully reduced. The scenarios also cover the rejection of particular targets (zero, equal to reference, too low, overflowing) and that a start during a busy computation leaves the result untouched.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_GCD,
    ST_DIV
  } pds_state_t;

  // Inclusive window test on a widened frequency value.
  function automatic logic in_window(input logic [31:0] f,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (f >= lo) && (f <= hi);
  endfunction
endpackage

// File: rtl/pds_search.sv
module pds_search #(
  parameter int TW     = 13,
  parameter int PDW    = 3,
  parameter int PD_MAX = 7,
  parameter int VCO_LO = 800,
  parameter int VCO_HI = 2000,
  localparam int VW    = TW + 2*PDW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [TW-1:0]  target,
  output logic           hit,
  output logic           miss,
  output logic [PDW-1:0] p1,
  output logic [PDW-1:0] p2,
  output logic [VW-1:0]  vco
);
  localparam logic [PDW-1:0] PMAX = PDW'(PD_MAX);
  localparam logic [PDW-1:0] PONE = PDW'(1);

  logic          active;
  logic [TW-1:0] tgt;
  logic          win, last;

  assign vco  = VW'(tgt) * VW'(p1) * VW'(p2);
  assign win  = pds_pkg::in_window(32'(vco), 32'(VCO_LO), 32'(VCO_HI));
  assign last = (p1 == PMAX) && (p2 == PMAX);
  assign hit  = active && win;
  assign miss = active && !win && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tgt    <= '0;
      p1     <= PONE;
      p2     <= PONE;
    end else if (go) begin
      active <= 1'b1;
      tgt    <= target;
      p1     <= PONE;
      p2     <= PONE;
    end else if (active) begin
      if (win || last) begin
        active <= 1'b0;
      end else if (p2 == PMAX) begin
        p2 <= PONE;
        p1 <= p1 + PONE;
      end else begin
        p2 <= p2 + PONE;
      end
    end
  end
endmodule

// File: rtl/pds_gcd.sv
module pds_gcd #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         ready,
  output logic [W-1:0] result
);
  logic         active;
  logic [W-1:0] a, b;

  assign ready  = active && (a == '0);
  assign result = b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      a      <= '0;
      b      <= '0;
    end else if (go) begin
      active <= 1'b1;
      a      <= a_in;
      b      <= b_in;
    end else if (active && (a != '0)) begin
      if (b > a) begin
        a <= b - a;   // swap folded into the subtract
        b <= a;
      end else begin
        a <= a - b;
      end
    end
  end
endmodule

// File: rtl/pds_seqdiv.sv
module pds_seqdiv #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         ready,
  output logic [W-1:0] quo
);
  logic         active;
  logic [W-1:0] rem, dq;

  assign ready = active && (rem < dq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem    <= '0;
      dq     <= '0;
      quo    <= '0;
    end else if (go) begin
      active <= 1'b1;
      rem    <= num;
      dq     <= den;
      quo    <= '0;
    end else if (active && (rem >= dq)) begin
      rem <= rem - dq;
      quo <= quo + W'(1);
    end
  end
endmodule

// File: rtl/pds_solver.sv
module pds_solver #(
  parameter int REF_MHZ = 24,
  parameter int TW      = 13,
  parameter int FBW     = 12,
  parameter int RDW     = 6,
  parameter int PDW     = 3,
  parameter int PD_MAX  = 7,
  parameter int VCO_LO  = 800,
  parameter int VCO_HI  = 2000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [TW-1:0]  target_mhz,
  output logic [RDW-1:0] refdiv,
  output logic [FBW-1:0] fbdiv,
  output logic [PDW-1:0] postdiv1,
  output logic [PDW-1:0] postdiv2,
  output logic           done,
  output logic           err
);
  import pds_pkg::*;

  localparam int VW = TW + 2*PDW;
  localparam logic [TW-1:0] REF_T  = TW'(REF_MHZ);
  localparam logic [TW-1:0] LO_T   = TW'(VCO_LO);
  localparam logic [VW-1:0] REF_V  = VW'(REF_MHZ);
  localparam logic [VW-1:0] FB_MAX = VW'((1 << FBW) - 1);
  localparam logic [VW-1:0] RD_MAX = VW'((1 << RDW) - 1);

  pds_state_t     st;
  logic [VW-1:0]  vco_q;
  logic [PDW-1:0] sp1, sp2;
  logic [RDW-1:0] rd_q;
  logic [FBW-1:0] fb_q;
  logic [PDW-1:0] p1_q, p2_q;
  logic           done_q, err_q;

  // Internal events, named for the checker.
  logic           bad_req, direct, accept;
  logic           srch_go, gcd_go, div_go;
  logic           s_hit, s_miss;
  logic [PDW-1:0] s_p1, s_p2;
  logic [VW-1:0]  s_vco;
  logic           g_ready;
  logic [VW-1:0]  g_val;
  logic [VW-1:0]  gcd_b;
  logic           rq_ready, fq_ready, div_ready, ovf;
  logic [VW-1:0]  rq, fq;

  assign accept  = (st == ST_IDLE) && start;
  assign bad_req = (target_mhz == '0) || (target_mhz == REF_T) || (REF_MHZ == 0);
  assign direct  = target_mhz >= LO_T;
  assign srch_go = accept && !bad_req && !direct;
  assign gcd_go  = (accept && !bad_req && direct) || ((st == ST_SEARCH) && s_hit);
  assign gcd_b   = (st == ST_SEARCH) ? s_vco : VW'(target_mhz);
  assign div_go  = (st == ST_GCD) && g_ready;
  assign div_ready = rq_ready && fq_ready;
  assign ovf     = (fq > FB_MAX) || (rq > RD_MAX) || (fq == '0) || (rq == '0);

  pds_search #(.TW(TW), .PDW(PDW), .PD_MAX(PD_MAX), .VCO_LO(VCO_LO), .VCO_HI(VCO_HI))
    u_search (.clk(clk), .rst_n(rst_n), .go(srch_go), .target(target_mhz),
              .hit(s_hit), .miss(s_miss), .p1(s_p1), .p2(s_p2), .vco(s_vco));

  pds_gcd #(.W(VW)) u_gcd (.clk(clk), .rst_n(rst_n), .go(gcd_go), .a_in(REF_V),
                           .b_in(gcd_b), .ready(g_ready), .result(g_val));

  pds_seqdiv #(.W(VW)) u_div_ref (.clk(clk), .rst_n(rst_n), .go(div_go), .num(REF_V),
                                  .den(g_val), .ready(rq_ready), .quo(rq));
  pds_seqdiv #(.W(VW)) u_div_fb  (.clk(clk), .rst_n(rst_n), .go(div_go), .num(vco_q),
                                  .den(g_val), .ready(fq_ready), .quo(fq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      vco_q <= '0; sp1 <= '0; sp2 <= '0;
      rd_q <= '0; fb_q <= '0; p1_q <= '0; p2_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          if (bad_req) begin
            rd_q <= '0; fb_q <= '0; p1_q <= '0; p2_q <= '0;
            err_q <= 1'b1; done_q <= 1'b1;
          end else if (direct) begin
            vco_q <= VW'(target_mhz);
            sp1 <= PDW'(1); sp2 <= PDW'(1);
            st <= ST_GCD;
          end else begin
            st <= ST_SEARCH;
          end
        end
        ST_SEARCH: if (s_hit) begin
          vco_q <= s_vco; sp1 <= s_p1; sp2 <= s_p2;
          st <= ST_GCD;
        end else if (s_miss) begin
          rd_q <= '0; fb_q <= '0; p1_q <= '0; p2_q <= '0;
          err_q <= 1'b1; done_q <= 1'b1;
          st <= ST_IDLE;
        end
        ST_GCD: if (g_ready) st <= ST_DIV;
        ST_DIV: if (div_ready) begin
          if (ovf) begin
            rd_q <= '0; fb_q <= '0; p1_q <= '0; p2_q <= '0;
            err_q <= 1'b1;
          end else begin
            rd_q <= rq[RDW-1:0]; fb_q <= fq[FBW-1:0];
            p1_q <= sp1; p2_q <= sp2;
            err_q <= 1'b0;
          end
          done_q <= 1'b1;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign refdiv   = rd_q;
  assign fbdiv    = fb_q;
  assign postdiv1 = p1_q;
  assign postdiv2 = p2_q;
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/pds_solver_chk.sv
module pds_solver_chk #(
  parameter int REF_MHZ = 24,
  parameter int FBW     = 12,
  parameter int RDW     = 6,
  parameter int PDW     = 3,
  parameter int PD_MAX  = 7,
  parameter int VCO_LO  = 800,
  parameter int VCO_HI  = 2000,
  parameter int VW      = 19
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           err,
  input logic [RDW-1:0] refdiv,
  input logic [FBW-1:0] fbdiv,
  input logic [PDW-1:0] postdiv1,
  input logic [PDW-1:0] postdiv2,
  input logic [VW-1:0]  vco_q
);
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (refdiv == '0 && fbdiv == '0 && postdiv1 == '0 && postdiv2 == '0)); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(refdiv) && $stable(fbdiv) && $stable(postdiv1)
               && $stable(postdiv2) && $stable(err))); // R7

  AST_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (32'(fbdiv) * 32'(REF_MHZ) == 32'(refdiv) * 32'(vco_q))); // R4

  AST_PD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (postdiv1 >= PDW'(1) && postdiv1 <= PDW'(PD_MAX)
                        && postdiv2 >= PDW'(1) && postdiv2 <= PDW'(PD_MAX))); // R2

  AST_VCO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && (postdiv1 != PDW'(1) || postdiv2 != PDW'(1)))
      |-> (32'(vco_q) >= 32'(VCO_LO) && 32'(vco_q) <= 32'(VCO_HI))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (fbdiv != '0 && refdiv != '0)); // R6
endmodule

bind pds_solver pds_solver_chk #(
  .REF_MHZ(REF_MHZ), .FBW(FBW), .RDW(RDW), .PDW(PDW), .PD_MAX(PD_MAX),
  .VCO_LO(VCO_LO), .VCO_HI(VCO_HI), .VW(TW + 2*PDW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .refdiv(refdiv),
  .fbdiv(fbdiv), .postdiv1(postdiv1), .postdiv2(postdiv2), .vco_q(vco_q)
);

// File: tb/pds_solver_test.sv
`timescale 1ns/1ps
module pds_solver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] target_mhz = '0;
  logic [5:0]  refdiv;
  logic [11:0] fbdiv;
  logic [2:0]  postdiv1, postdiv2;
  logic        done, err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  pds_solver uut (.clk(clk), .rst_n(rst_n), .start(start), .target_mhz(target_mhz),
                  .refdiv(refdiv), .fbdiv(fbdiv), .postdiv1(postdiv1),
                  .postdiv2(postdiv2), .done(done), .err(err));

  function automatic int euclid(input int x, input int y);
    int a = x, b = y, t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  // Independent model of the requirements: fixed 24 MHz reference.
  function automatic void model(input int t, output int p1, output int p2,
                                output int rd, output int fb, output int e);
    int v = 0, g;
    bit found = 0;
    p1 = 0; p2 = 0; rd = 0; fb = 0; e = 0;
    if (t == 0 || t == 24) e = 1;
    else if (t >= 800) begin p1 = 1; p2 = 1; v = t; end
    else begin
      for (int a = 1; a <= 7; a++)
        for (int b = 1; b <= 7; b++)
          if (!found && t*a*b >= 800 && t*a*b <= 2000) begin
            found = 1; p1 = a; p2 = b; v = t*a*b;
          end
      if (!found) e = 1;
    end
    if (!e) begin
      g = euclid(24, v); rd = 24 / g; fb = v / g;
      if (fb > 4095 || rd > 63) e = 1;
    end
    if (e) begin p1 = 0; p2 = 0; rd = 0; fb = 0; end
  endfunction

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic compare(input int t, input string req);
    int p1, p2, rd, fb, e;
    model(t, p1, p2, rd, fb, e);
    checks++;
    if (done !== 1'b1 || err !== e[0] || refdiv !== rd[5:0] || fbdiv !== fb[11:0]
        || postdiv1 !== p1[2:0] || postdiv2 !== p2[2:0]) begin
      fails++;
      $display("FAIL %s target=%0d: got done=%0d err=%0d rd=%0d fb=%0d pd=%0d/%0d exp err=%0d rd=%0d fb=%0d pd=%0d/%0d",
               req, t, done, err, refdiv, fbdiv, postdiv1, postdiv2, e, rd, fb, p1, p2);
    end
  endtask

  task automatic run_case(input int t, input string req);
    @(negedge clk); start = 1'b1; target_mhz = 13'(t);
    @(negedge clk); start = 1'b0;
    wait_done();
    compare(t, req);
  endtask

  // R8: second start during a computation must be ignored.
  task automatic busy_case();
    @(negedge clk); start = 1'b1; target_mhz = 13'd1000;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; target_mhz = 13'd600;
    @(negedge clk); start = 1'b0;
    wait_done();
    compare(1000, "R8");
  endtask

  // R7: done lasts one cycle, outputs hold afterwards.
  task automatic pulse_case();
    logic [11:0] fb0;
    run_case(100, "R2");
    fb0 = fbdiv;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || fbdiv !== fb0) begin
      fails++;
      $display("FAIL R7: done=%0d fb=%0d exp done=0 fb=%0d", done, fbdiv, fb0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 0 || err !== 0 || refdiv !== 0 || fbdiv !== 0 || postdiv1 !== 0 || postdiv2 !== 0) begin
      fails++;
      $display("FAIL R9: done=%0d err=%0d rd=%0d fb=%0d exp all 0", done, err, refdiv, fbdiv);
    end
    rst_n = 1'b1;
    run_case(0, "R1");
    run_case(24, "R1");
    run_case(1000, "R3");
    run_case(2000, "R3");
    run_case(600, "R2");
    pulse_case();
    run_case(799, "R2");
    run_case(17, "R2");
    run_case(16, "R5");
    run_case(5000, "R4");
    run_case(4099, "R6");
    busy_case();
    run_case(1200, "R4");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, got cycle %0d exp < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
      $finish;
    end
  end
endmodule